// File: doc/BRIEF.md
# Access Attribute Resolution Unit

This unit decides, for every memory reference, how the reference is to be treated. It takes the upper byte of the access address and compares it against two programmable address windows. Each window has a base tag, a don't-care mask, an enable, a cache mode and a write-protect bit. The first window always wins over the second. When neither window claims the address, a default mode held in a control register applies. The unit reports three things:

- the effective two-bit mode;
- whether the reference may be cached;
- whether a write has struck a protected window.

Software sets up the three registers through a single-cycle write port. A lookup is purely combinational, from the address and the stored register values. A write changes the lookup result from the next cycle on. Reset clears all three registers. After reset caching is off and both windows are disabled.

Top module: `attr_resolve`

## Requirements
- R1: After reset every register reads as zero: both windows are disabled, `cacheable` is 0, `eff_mode` is 00, `win_sel` is 00 and `wp_fault` is 0. `cacheable` stays 0 until the control register is written.
- R2: An enabled window matches when, for every bit position where its mask (window register bits 23:16) holds 0, address bits 31:24 equal its base (window register bits 31:24). A match of the first window drives `eff_mode` from its mode field (bits 6:5) and sets `win_sel` to 01.
- R3: When both enabled windows match the same address, the first window's attributes are used and `win_sel` is 01.
- R4: When the first window does not match and the second does, the second window's mode applies and `win_sel` is 10.
- R5: When no window matches, `eff_mode` takes the default-mode field of the control register (bits 6:5), `win_sel` is 00 and `wp_fault` is 0.
- R6: A window whose enable bit (bit 15) is 0 never matches, whatever its base and mask.
- R7: `wp_fault` is 1 exactly when `acc_write` is 1 and the winning window has its write-protect bit (bit 2) set. Read accesses never raise it.
- R8: `cacheable` is 1 only when the control register's cache-on bit (bit 31) is 1 and `eff_mode[1]` is 0. Mode 00 and mode 01 are cacheable. The inhibited modes 10 and 11 both give `cacheable` = 0.
- R9: With `wr_en` high at a rising edge, `wr_sel` 0 loads the control register, 1 loads the first window and 2 loads the second window. `wr_sel` 3 changes nothing. The new value affects the outputs only after that edge.
- R10: Address bits 23:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 first window, 2 second window |
| wr_data | input | 32 | Register write data |
| acc_addr | input | 32 | Address of the current access |
| acc_write | input | 1 | Current access is a write |
| eff_mode | output | 2 | Effective cache mode |
| cacheable | output | 1 | Access may be cached |
| wp_fault | output | 1 | Write to a protected window |
| win_sel | output | 2 | Deciding window: 01 first, 10 second, 00 default |

## Verification
The hardest case to reach from the ports is two enabled windows that overlap, with masks and bases that differ. Only then do the priority and the fall-through to the second window both show. Purely random 32-bit values almost never produce such overlaps. The random stimulus therefore draws window bases and access tags from a narrow set of neighbouring upper-byte values, and uses masks that mostly clear only a few low bits. Directed steps build an exact overlap, then disable the first window to expose the second. They also sample one cycle before a register write lands, to show that the write only takes effect after the edge.

// File: rtl/attr_resolve.sv
module attr_resolve #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  output logic [1:0]    eff_mode,
  output logic          cacheable,
  output logic          wp_fault,
  output logic [1:0]    win_sel
);
  localparam int NWIN = 2;

  logic [CW-1:0] tag;
  logic          ctl_on;
  logic [1:0]    ctl_dflt;
  logic [CW-1:0] w_base [NWIN];
  logic [CW-1:0] w_mask [NWIN];
  logic          w_en   [NWIN];
  logic [1:0]    w_mode [NWIN];
  logic          w_wp   [NWIN];
  logic [NWIN-1:0] hit;

  assign tag = acc_addr[AW-1 -: CW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_on   <= 1'b0;
      ctl_dflt <= 2'b00;
    end else if (wr_en && wr_sel == 2'd0) begin
      ctl_on   <= wr_data[31];
      ctl_dflt <= wr_data[6:5];
    end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        w_base[g] <= '0;
        w_mask[g] <= '0;
        w_en[g]   <= 1'b0;
        w_mode[g] <= 2'b00;
        w_wp[g]   <= 1'b0;
      end else if (wr_en && wr_sel == 2'(g + 1)) begin
        w_base[g] <= wr_data[31 -: CW];
        w_mask[g] <= wr_data[23 -: CW];
        w_en[g]   <= wr_data[15];
        w_mode[g] <= wr_data[6:5];
        w_wp[g]   <= wr_data[2];
      end
    assign hit[g] = w_en[g] && (((tag ^ w_base[g]) & ~w_mask[g]) == '0);
  end

  assign win_sel   = hit[0] ? 2'b01 : (hit[1] ? 2'b10 : 2'b00);
  assign eff_mode  = hit[0] ? w_mode[0] : (hit[1] ? w_mode[1] : ctl_dflt);
  assign wp_fault  = acc_write && (hit[0] ? w_wp[0] : (hit[1] && w_wp[1]));
  assign cacheable = ctl_on && !eff_mode[1];
endmodule

module attr_resolve_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       acc_write,
  input logic [1:0] eff_mode,
  input logic       cacheable,
  input logic       wp_fault,
  input logic [1:0] win_sel
);
  logic ctl_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_seen <= 1'b0;
    else if (wr_en && wr_sel == 2'd0) ctl_seen <= 1'b1;

  // R1
  caching_off_until_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_seen |-> !cacheable);
  // R3
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel));
  // R5
  default_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel == 2'b00 |-> !wp_fault);
  // R7
  read_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_write |-> !wp_fault);
  // R8
  inhibit_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_mode[1] |-> !cacheable);
endmodule

bind attr_resolve attr_resolve_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .acc_write(acc_write), .eff_mode(eff_mode), .cacheable(cacheable),
  .wp_fault(wp_fault), .win_sel(win_sel)
);

// File: tb/attr_resolve_test.sv
module attr_resolve_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [1:0]  eff_mode;
  logic        cacheable, wp_fault;
  logic [1:0]  win_sel;

  int total = 0, fails = 0;
  logic [31:0] m_ctl = '0, m_w0 = '0, m_w1 = '0;

  always #4 clk = ~clk;

  attr_resolve uut (.*);

  function automatic logic [31:0] mk_win(logic [7:0] b, logic [7:0] m, logic en, logic [1:0] md, logic wp);
    return {b, m, en, 8'd0, md, 2'd0, wp, 2'd0};
  endfunction

  function automatic logic wmatch(logic [31:0] w, logic [7:0] t);
    return w[15] && (((t ^ w[31:24]) & ~w[23:16]) == 8'd0);
  endfunction

  // expected {win_sel, eff_mode, cacheable, wp_fault}
  function automatic logic [5:0] model(logic [31:0] a, logic wr);
    logic [1:0] ws, md; logic wp;
    if (wmatch(m_w0, a[31:24]))      begin ws = 2'b01; md = m_w0[6:5]; wp = m_w0[2]; end
    else if (wmatch(m_w1, a[31:24])) begin ws = 2'b10; md = m_w1[6:5]; wp = m_w1[2]; end
    else                             begin ws = 2'b00; md = m_ctl[6:5]; wp = 1'b0; end
    return {ws, md, m_ctl[31] && !md[1], wr && wp};
  endfunction

  task automatic check(string req);
    logic [5:0] exp, act;
    exp = model(acc_addr, acc_write);
    act = {win_sel, eff_mode, cacheable, wp_fault};
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b actual=%b expected=%b", req, acc_addr, acc_write, act, exp);
    end
  endtask

  task automatic probe(logic [31:0] a, logic wr, string req);
    @(negedge clk); acc_addr = a; acc_write = wr; #1; check(req);
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    case (s)
      2'd0: m_ctl = d;
      2'd1: m_w0 = d;
      2'd2: m_w1 = d;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] near_tag();
    return {6'b101000, 2'($urandom)};
  endfunction

  initial begin
    #(8 * 150000);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #20 rst_n = 1'b1;
    probe(32'hA000_0000, 1'b1, "R1");
    if (cacheable !== 1'b0 || win_sel !== 2'b00) begin fails++; total++; $display("FAIL R1 reset outputs actual=%b%b expected=000", cacheable, win_sel); end
    else total++;

    // R9: control write not visible before the edge
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h8000_0000; #1;
    check("R9 before edge");
    @(negedge clk); wr_en = 1'b0; m_ctl = 32'h8000_0000; #1;
    check("R9 after edge");
    probe(32'h1234_5678, 1'b0, "R5");

    wr(2'd1, mk_win(8'hA0, 8'h00, 1'b1, 2'b10, 1'b1));
    probe(32'hA000_0010, 1'b1, "R2 R7");
    probe(32'hA0FF_FFFF, 1'b0, "R7 read");
    probe(32'hA1FF_FFFF, 1'b1, "R5 miss");

    wr(2'd2, mk_win(8'hA0, 8'h0F, 1'b1, 2'b01, 1'b0));
    probe(32'hA000_0000, 1'b1, "R3");
    probe(32'hA512_3456, 1'b1, "R4");
    probe(32'hA5FF_0000, 1'b0, "R10");
    probe(32'hB500_0000, 1'b1, "R5");

    wr(2'd1, mk_win(8'hA0, 8'h00, 1'b0, 2'b10, 1'b1));
    probe(32'hA000_0000, 1'b1, "R6");
    wr(2'd3, 32'hFFFF_FFFF);
    probe(32'hA000_0000, 1'b1, "R9 sel3");
    probe(32'h0000_0000, 1'b1, "R9 sel3");

    wr(2'd0, 32'h8000_0060);
    probe(32'h0100_0000, 1'b0, "R8 mode11");
    wr(2'd0, 32'h8000_0040);
    probe(32'h0100_0000, 1'b0, "R8 mode10");
    wr(2'd0, 32'h8000_0020);
    probe(32'h0100_0000, 1'b0, "R8 mode01");

    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 5);
      if (k == 0) wr(2'($urandom), {$urandom_range(0,1) ? near_tag() : 8'($urandom), 24'($urandom)});
      else if (k == 1) wr(2'($urandom_range(1,2)),
             mk_win(near_tag(), $urandom_range(0,4) == 0 ? 8'hFF : 8'($urandom) & 8'h03,
                    $urandom_range(0,3) != 0, 2'($urandom), 1'($urandom)));
      else probe({$urandom_range(0,2) != 0 ? near_tag() : 8'($urandom), 24'($urandom)},
                 1'($urandom), "R2 R3 R4 R5 R7 R8 R10 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule